// File: doc/BRIEF.md
# Write-Masked PHY Configuration Bridge

This block connects a processor register bus to the indirect configuration port of a multi-lane serial PHY. A control register holds a configuration address, a configuration data nibble and a write strobe. Software moves these fields through a bus write whose upper half-word acts as a per-bit write enable, so a single field can be changed without reading the register first. A rising edge on the strobe bit commits the data nibble into the configuration space at the selected address. A status register gives back the content at a 10-bit selector, the receiver-detect flag of a lane status word, and two PLL indicators.

The PHY side is modelled inside the block. It has a 64-entry, 4-bit configuration array, four lane status words whose receiver-detect flag comes from input pins, and a PLL lock tracker. The tracker reports lock after a programmable number of cycles in which the PHY is out of reset and the PLL lock location is selected. A second masked register holds one idle control per lane and drives the lane idle pins. Reads complete one cycle after they are accepted.

Top module: `phycfg_bridge`

## Requirements
- R1: A write to the control register (byte offset 0x0) changes bit n of the low half-word (n in 0..15) only when bit n+16 of the write data is 1; every other bit keeps its previous value. Control bits 15:11 always read 0.
- R2: Control bits 10:7 are the configuration data and bits 6:1 the configuration address. Only a 0-to-1 change of control bit 0 stores the data into the array entry at that address. Keeping bit 0 high, changing fields while it is high, or clearing it stores nothing.
- R3: Reading the status register (byte offset 0x4) returns in bits 3:0 the array entry chosen by the 10-bit selector in control bits 10:1 when the selector is below 64, and 0 when it is 64 or more.
- R4: Status bit 11 equals lane_rx_det[i] when the selector equals 0x30+i for a lane i that exists (i < LANES). It is 0 for every other selector.
- R5: Status bit 9 and the pll_locked output rise on the LOCK_CYCLES-th consecutive clock edge at which phy_reset is low and control bits 6:1 equal 0x10. A break in that condition restarts the count. Once set, lock holds until a reset.
- R6: A cycle with phy_reset high clears every array entry and the lock indication.
- R7: The lane-off register (byte offset 0x8) uses the same masked write. Bit 3+i is the idle control of lane i and drives lane_idle[i]. All other bits read 0.
- R8: Status bit 10 (PLL output active) is 1 only when the PLL is locked and at least one lane is not idle.
- R9: req_ready is always 1, and each accepted read gives exactly one rsp_valid pulse in the following cycle. Reads of unmapped offsets return 0. Writes to unmapped offsets or to the status offset change nothing.
- R10: With rst_n low, the control and lane-off registers, the array and the lock state all return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the whole block |
| phy_reset | input | 1 | Synchronous PHY reset; clears the array and the lock |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data; upper half is the bit write enable |
| rsp_valid | output | 1 | Read data valid, one cycle after the read is accepted |
| rsp_rdata | output | 32 | Read data |
| lane_rx_det | input | LANES | Receiver-detect flag of each lane |
| lane_idle | output | LANES | Idle control of each lane |
| pll_locked | output | 1 | PLL lock indication |

## Verification
A write to a masked register takes effect at the edge that accepts it. A strobe rise commits to the array one edge later, so the bench always places at least one more accepted access before it reads the entry back. Read data is registered, so the scoreboard pops an expected word at the falling edge that follows the accepting edge, where rsp_valid is high for exactly that one cycle. The lock indication is probed at the falling edge just before and just after the LOCK_CYCLES-th qualifying edge, counted from the edge that wrote the lock selector, so that an early or a late lock shows up as a mismatch.

// File: rtl/phycfg_pkg.sv
package phycfg_pkg;

  localparam int unsigned HALF_W = 16;
  localparam int unsigned WORD_W = 32;

  // Byte offsets of the three mapped registers
  localparam int unsigned OFF_CTRL = 'h0;
  localparam int unsigned OFF_STAT = 'h4;
  localparam int unsigned OFF_LANE = 'h8;

  // Control field layout (bit positions are decoded by the PHY side)
  localparam int unsigned STB_BIT   = 0;
  localparam int unsigned ADDR_LSB  = 1;
  localparam int unsigned ADDR_W6   = 6;
  localparam int unsigned DATA_LSB  = 7;
  localparam int unsigned DATA_W4   = 4;
  localparam int unsigned SEL_W     = ADDR_W6 + DATA_W4;
  localparam logic [HALF_W-1:0] CTRL_IMPL = 16'h07FF;

  // Status layout
  localparam int unsigned ST_LOCK_BIT  = 9;
  localparam int unsigned ST_ACT_BIT   = 10;
  localparam int unsigned ST_RXDET_BIT = 11;

  // Lane-off layout
  localparam int unsigned IDLE_LSB = 3;

  // Masked update of a half-word: high half of wr enables low half bits
  function automatic logic [HALF_W-1:0] hw_merge(
    input logic [HALF_W-1:0] cur,
    input logic [WORD_W-1:0] wr,
    input logic [HALF_W-1:0] impl
  );
    logic [HALF_W-1:0] en;
    en = wr[WORD_W-1:HALF_W];
    return ((cur & ~en) | (wr[HALF_W-1:0] & en)) & impl;
  endfunction

  // Implemented bits of the lane-off register for a lane count
  function automatic logic [HALF_W-1:0] lane_mask(input int unsigned lanes);
    logic [HALF_W-1:0] m;
    m = '0;
    for (int i = 0; i < lanes; i++) m[IDLE_LSB+i] = 1'b1;
    return m;
  endfunction

  // Assemble the status word
  function automatic logic [WORD_W-1:0] pack_status(
    input logic [DATA_W4-1:0] cfg,
    input logic rxdet,
    input logic lock,
    input logic active
  );
    logic [WORD_W-1:0] s;
    s = '0;
    s[DATA_W4-1:0]  = cfg;
    s[ST_LOCK_BIT]  = lock;
    s[ST_ACT_BIT]   = active;
    s[ST_RXDET_BIT] = rxdet;
    return s;
  endfunction

endpackage

// File: rtl/phycfg_maskreg.sv
module phycfg_maskreg
  import phycfg_pkg::*;
#(
  parameter logic [HALF_W-1:0] IMPL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [HALF_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (wr_en) q <= hw_merge(q, wr_data, IMPL);
  end

  // R1
  masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((q ^ $past(q)) & ~$past(wr_data[WORD_W-1:HALF_W])) == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/phycfg_space.sv
module phycfg_space
  import phycfg_pkg::*;
#(
  parameter int unsigned CFG_AW    = 6,
  parameter int unsigned CFG_DW    = 4,
  parameter int unsigned SELW      = 10,
  parameter int unsigned LANES     = 4,
  parameter int unsigned LANE_BASE = 'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phy_reset,
  input  logic              strobe,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [CFG_DW-1:0] wr_data,
  input  logic [SELW-1:0]   sel,
  input  logic [LANES-1:0]  lane_rx_det,
  output logic [CFG_DW-1:0] rd_data,
  output logic              rd_rxdet,
  output logic              wr_pulse
);

  localparam int unsigned DEPTH = 1 << CFG_AW;

  logic [CFG_DW-1:0] mem_q [DEPTH];
  logic              strobe_q;
  logic              in_range;
  logic [CFG_AW-1:0] idx;
  logic [LANES-1:0]  lane_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign wr_pulse = strobe & ~strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else if (phy_reset) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else if (wr_pulse) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign in_range = (sel[SELW-1:CFG_AW] == '0);
  assign idx      = sel[CFG_AW-1:0];
  assign rd_data  = in_range ? mem_q[idx] : '0;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_hit[i] = in_range && (idx == CFG_AW'(LANE_BASE + i));
  end

  assign rd_rxdet = |(lane_hit & lane_rx_det);

  // R2
  edge_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && !phy_reset) |=> (mem_q[$past(wr_addr)] == $past(wr_data)));

  // R6
  phy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_reset |=> (rd_data == '0));

endmodule

// File: rtl/phycfg_pll.sv
module phycfg_pll
  import phycfg_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 20,
  parameter int unsigned LOCK_ADDR   = 'h10,
  parameter int unsigned CFG_AW      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phy_reset,
  input  logic [CFG_AW-1:0] sel_addr,
  output logic              locked,
  output logic              lock_cond
);

  localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign lock_cond = !phy_reset && (sel_addr == CFG_AW'(LOCK_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      locked <= 1'b0;
    end else if (phy_reset) begin
      cnt_q  <= '0;
      locked <= 1'b0;
    end else if (!locked) begin
      if (!lock_cond)                         cnt_q  <= '0;
      else if (cnt_q == CNT_W'(LOCK_CYCLES - 1)) locked <= 1'b1;
      else                                    cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R5
  lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(lock_cond));

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !phy_reset) |=> locked);

  // R6
  lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_reset |=> !locked);

endmodule

// File: rtl/phycfg_bridge.sv
module phycfg_bridge
  import phycfg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned LANES       = 4,
  parameter int unsigned LOCK_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phy_reset,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [LANES-1:0]  lane_rx_det,
  output logic [LANES-1:0]  lane_idle,
  output logic              pll_locked
);

  localparam logic [HALF_W-1:0] LANE_IMPL = lane_mask(LANES);

  logic              accept;
  logic              hit_ctrl, hit_stat, hit_lane, unmapped;
  logic              wr_ctrl, wr_lane;
  logic [HALF_W-1:0] ctrl_q, lane_q;
  logic [DATA_W4-1:0] cfg_rd;
  logic              cfg_rx;
  logic              cfg_wr_pulse;
  logic              lock_cond;
  logic              pll_active;
  logic [WORD_W-1:0] status_w;
  logic [WORD_W-1:0] rd_mux;

  assign req_ready = 1'b1;
  assign accept    = req_valid && req_ready;
  assign hit_ctrl  = (req_addr == ADDR_W'(OFF_CTRL));
  assign hit_stat  = (req_addr == ADDR_W'(OFF_STAT));
  assign hit_lane  = (req_addr == ADDR_W'(OFF_LANE));
  assign unmapped  = !(hit_ctrl || hit_stat || hit_lane);
  assign wr_ctrl   = accept && req_write && hit_ctrl;
  assign wr_lane   = accept && req_write && hit_lane;

  phycfg_maskreg #(.IMPL(CTRL_IMPL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wr_data(req_wdata), .q(ctrl_q)
  );

  phycfg_maskreg #(.IMPL(LANE_IMPL)) u_laneoff (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_lane), .wr_data(req_wdata), .q(lane_q)
  );

  phycfg_space #(
    .CFG_AW(ADDR_W6), .CFG_DW(DATA_W4), .SELW(SEL_W), .LANES(LANES), .LANE_BASE('h30)
  ) u_space (
    .clk(clk), .rst_n(rst_n), .phy_reset(phy_reset),
    .strobe(ctrl_q[STB_BIT]),
    .wr_addr(ctrl_q[ADDR_LSB +: ADDR_W6]),
    .wr_data(ctrl_q[DATA_LSB +: DATA_W4]),
    .sel(ctrl_q[ADDR_LSB +: SEL_W]),
    .lane_rx_det(lane_rx_det),
    .rd_data(cfg_rd), .rd_rxdet(cfg_rx), .wr_pulse(cfg_wr_pulse)
  );

  phycfg_pll #(.LOCK_CYCLES(LOCK_CYCLES), .LOCK_ADDR('h10), .CFG_AW(ADDR_W6)) u_pll (
    .clk(clk), .rst_n(rst_n), .phy_reset(phy_reset),
    .sel_addr(ctrl_q[ADDR_LSB +: ADDR_W6]),
    .locked(pll_locked), .lock_cond(lock_cond)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_idle
    assign lane_idle[i] = lane_q[IDLE_LSB + i];
  end

  assign pll_active = pll_locked && !(&lane_idle);
  assign status_w   = pack_status(cfg_rd, cfg_rx, pll_locked, pll_active);

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)      rd_mux = {16'h0, ctrl_q};
    else if (hit_stat) rd_mux = status_w;
    else if (hit_lane) rd_mux = {16'h0, lane_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept && !req_write;
      if (accept && !req_write) rsp_rdata <= rd_mux;
    end
  end

  // R9
  rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && unmapped) |=> (rsp_rdata == '0));

  // R8
  active_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_rdata[ST_ACT_BIT] && $past(hit_stat)) |-> pll_locked);

endmodule

// File: tb/phycfg_bridge_test.sv
module phycfg_bridge_test;

  localparam int LC = 20;
  localparam int LN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phy_reset = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [LN-1:0] lane_rx_det = '0;
  logic [LN-1:0] lane_idle;
  logic        pll_locked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [3:0]  mem_m [64];
  logic        locked_m = 1'b0;
  logic [3:0]  idle_m = '0;

  always #10 clk = ~clk;

  phycfg_bridge #(.ADDR_W(4), .LANES(LN), .LOCK_CYCLES(LC)) uut (
    .clk(clk), .rst_n(rst_n), .phy_reset(phy_reset),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .lane_rx_det(lane_rx_det), .lane_idle(lane_idle), .pll_locked(pll_locked)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare each response against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  function automatic logic [31:0] exp_status(input logic [9:0] sel);
    logic [31:0] s;
    s = '0;
    if (sel < 64) begin
      s[3:0] = mem_m[sel[5:0]];
      if (sel >= 10'h30 && sel < 10'h30 + LN) s[11] = lane_rx_det[sel - 10'h30];
    end
    s[9]  = locked_m;
    s[10] = locked_m && (idle_m != 4'hF);
    return s;
  endfunction

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [3:0] d);
    bus_write(4'h0, {16'h07FE, 5'b0, d, a, 1'b0});
    bus_write(4'h0, {16'h0001, 16'h0001});
    mem_m[a] = d;
    bus_write(4'h0, {16'h0001, 16'h0000});
  endtask

  task automatic cfg_sel(input logic [9:0] s);
    bus_write(4'h0, {16'h07FE, 5'b0, s, 1'b0});
  endtask

  task automatic stat_read(input logic [9:0] s, input string tag);
    cfg_sel(s);
    bus_read(4'h4, exp_status(s), tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 64; k++) mem_m[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    chk("R10 pll_locked at reset", {31'b0, pll_locked}, 32'h0);
    chk("R10 lane_idle at reset", {28'b0, lane_idle}, 32'h0);
    chk("R9 req_ready high", {31'b0, req_ready}, 32'h1);
    bus_read(4'h0, 32'h0, "R10 ctrl after reset");
    bus_read(4'h8, 32'h0, "R10 laneoff after reset");
    bus_read(4'h4, 32'h0, "R10 status after reset");

    // R1 masked writes
    bus_write(4'h0, {16'h0003, 16'h07FF});
    bus_read(4'h0, 32'h0003, "R1 only enabled bits set");
    bus_write(4'h0, {16'h0001, 16'h0000});
    bus_read(4'h0, 32'h0002, "R1 single bit clear");
    bus_write(4'h0, {16'h0000, 16'hFFFF});
    bus_read(4'h0, 32'h0002, "R1 no enables no change");
    bus_write(4'h0, {16'hF800, 16'hFFFF});
    bus_read(4'h0, 32'h0002, "R1 bits 15:11 read zero");

    // R2 / R3 / R4 configuration access
    cfg_write(6'h05, 4'hA);
    cfg_write(6'h30, 4'h3);
    cfg_write(6'h3F, 4'hF);
    lane_rx_det = 4'b0001;
    stat_read(10'h005, "R3 entry 5");
    stat_read(10'h03F, "R3 entry 63");
    stat_read(10'h030, "R4 lane A with rx");
    stat_read(10'h031, "R4 lane B no rx");
    lane_rx_det = 4'b0010;
    stat_read(10'h031, "R4 lane B rx");
    lane_rx_det = 4'b1111;
    stat_read(10'h034, "R4 no fifth lane");
    stat_read(10'h045, "R3 selector above 63");

    // R2 strobe held high: no further commit
    bus_write(4'h0, {16'h07FE, 5'b0, 4'h6, 6'h07, 1'b0});
    bus_write(4'h0, {16'h0001, 16'h0001});
    mem_m[7] = 4'h6;
    bus_write(4'h0, {16'h0780, 5'b0, 4'h2, 7'b0});
    bus_write(4'h0, {16'h0001, 16'h0000});
    stat_read(10'h007, "R2 no commit without rising strobe");

    // R7 lane-off register
    bus_write(4'h8, {16'h0078, 16'h0028});
    idle_m = 4'b0101;
    bus_read(4'h8, 32'h0028, "R7 masked laneoff");
    @(negedge clk);
    chk("R7 lane_idle pattern", {28'b0, lane_idle}, {28'b0, idle_m});
    bus_write(4'h8, 32'hFFFF_FFFF);
    idle_m = 4'hF;
    bus_read(4'h8, 32'h0078, "R7 unused bits zero");
    bus_write(4'h8, {16'h0008, 16'h0000});
    idle_m = 4'b1110;
    @(negedge clk);
    chk("R7 lane A released", {28'b0, lane_idle}, {28'b0, idle_m});

    // R9 unmapped and status writes
    bus_read(4'hC, 32'h0, "R9 unmapped read zero");
    bus_write(4'hC, 32'hFFFF_FFFF);
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_read(4'h0, 32'h000E, "R9 ctrl untouched by ignored writes");
    bus_read(4'h8, 32'h0070, "R9 laneoff untouched by ignored writes");

    // R5 interrupted lock attempt
    cfg_sel(10'h010);
    repeat (5) @(posedge clk);
    cfg_sel(10'h005);
    cfg_sel(10'h010);
    repeat (LC - 1) @(posedge clk);
    @(negedge clk);
    chk("R5 not locked one edge early", {31'b0, pll_locked}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R5 locked on count", {31'b0, pll_locked}, 32'h1);
    locked_m = 1'b1;
    bus_read(4'h4, exp_status(10'h010), "R5 R8 status locked active");
    bus_write(4'h8, 32'hFFFF_FFFF);
    idle_m = 4'hF;
    bus_read(4'h4, exp_status(10'h010), "R8 inactive when all idle");
    bus_write(4'h8, {16'h0078, 16'h0000});
    idle_m = 4'h0;
    stat_read(10'h005, "R5 lock holds after deselect");

    // R6 PHY reset
    @(negedge clk);
    phy_reset = 1'b1;
    @(negedge clk);
    phy_reset = 1'b0;
    locked_m = 1'b0;
    for (int k = 0; k < 64; k++) mem_m[k] = '0;
    chk("R6 lock cleared", {31'b0, pll_locked}, 32'h0);
    stat_read(10'h005, "R6 entry cleared");
    stat_read(10'h03F, "R6 top entry cleared");

    // R10 full reset
    bus_write(4'h8, {16'h0010, 16'h0010});
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10 lane_idle cleared", {28'b0, lane_idle}, 32'h0);
    bus_read(4'h0, 32'h0, "R10 ctrl cleared");
    bus_read(4'h8, 32'h0, "R10 laneoff cleared");

    repeat (3) @(negedge clk);
    chk("R9 scoreboard drained", exp_q.size(), 32'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule